// File: doc/BRIEF.md
# Mode Register Write Sequencer

This block sits in a DRAM controller's command path and turns a software-style request into a safe mode register set command. A request names a register through a bank-address selector and supplies an opcode. The block holds the request in a single pending slot until the device is idle. Idle means no bank has an open row, every bank's precharge interval has elapsed, no data burst is in flight and the clock enable is high. It then drives the mode register set command onto the command/address bus for one cycle.

After the command, the block keeps the bus in NOP for the rest of the register update window, so no other command can reach the device while the new setting is not yet in effect. A further mode register set may still go out during that window, and doing so restarts the window. When the window runs out, the block raises a one-cycle done pulse. It then refuses requests for that cycle and the one after it.

Top module: `mr_write_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the bus is deselect (cs_n=1, ras_n=1, cas_n=1, we_n=1, ba=0, addr=0), busy=0 and done=0.
- R2: A mode register set appears on the bus as cs_n=0, ras_n=0, cas_n=0, we_n=0 for one cycle, with ba equal to the request's selector and addr equal to its opcode.
- R3: No mode register set is issued on the cycle after an edge at which any bit of bank_open was 1.
- R4: No mode register set is issued on the cycle after an edge at which any bit of bank_trp_busy was 1.
- R5: No mode register set is issued on the cycle after an edge at which burst_active was 1 or cke_high was 0.
- R6: On each of the UPD_CYC-1 cycles after a mode register set, the bus carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, ba=0, addr=0), unless another mode register set is issued.
- R7: done is high for exactly one cycle, UPD_CYC cycles after the last mode register set, and the bus is deselect on that cycle.
- R8: A request accepted during the update window is issued as soon as the device is idle, without waiting for the window to end, and the window restarts from that command.
- R9: busy is high whenever a request is pending. A request sampled while busy is high is dropped and never reaches the bus.
- R10: busy is high on the done cycle and on the cycle after it, so requests sampled there are dropped.
- R11: Outside an update window, and when no request can be issued, the bus carries deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled when busy is low |
| req_sel | input | SEL_W | Mode register selector (driven onto ba) |
| req_opcode | input | ADDR_W | Opcode (driven onto addr) |
| bank_open | input | NUM_BANKS | Per-bank open row flag |
| bank_trp_busy | input | NUM_BANKS | Per-bank flag, high while the precharge interval is running |
| burst_active | input | 1 | A data burst is in progress |
| cke_high | input | 1 | Current clock-enable level |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | SEL_W | Bank address / register selector |
| addr | output | ADDR_W | Address / opcode |
| busy | output | 1 | Request would be dropped this cycle |
| done | output | 1 | One-cycle pulse at the end of the update window |

## Verification
The bench releases the idle conditions one at a time, so a request stays pending behind a single open bank, a single unfinished precharge, a running burst or a low clock enable. A gate that ignored any one of these would put the command on the bus a cycle too early. It sends a second request inside the update window. A design that queued the request behind the window would show extra NOPs, and one that did not restart the window would raise done too soon. It also sends requests during a pending slot, on the done cycle and on the cycle after it. A design that accepted any of these would overwrite the opcode or emit an extra command. A long random stretch, checked cycle by cycle against a behavioural model, covers the combinations.

// File: rtl/mr_write_pkg.sv
package mr_write_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WIN  = 2'd1,
    PH_DONE = 2'd2,
    PH_GAP  = 2'd3
  } phase_t;

  function automatic cmd_t cmd_mrs();
    return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  endfunction

  function automatic cmd_t cmd_nop();
    return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  endfunction

  function automatic cmd_t cmd_des();
    return '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  endfunction

  // Requests are refused while a slot is held or in the post-window cycles.
  function automatic logic refuse_req(input logic slot_full, input phase_t ph);
    return slot_full || (ph == PH_DONE) || (ph == PH_GAP);
  endfunction

endpackage

// File: rtl/mr_idle_gate.sv
module mr_idle_gate #(
  parameter int NUM_BANKS = 8
) (
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic [NUM_BANKS-1:0] bank_trp_busy,
  input  logic                 burst_active,
  input  logic                 cke_high,
  output logic                 dev_idle
);
  logic [NUM_BANKS-1:0] bank_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_ready[b] = ~bank_open[b] & ~bank_trp_busy[b];
  end

  assign dev_idle = (&bank_ready) & ~burst_active & cke_high;
endmodule

// File: rtl/mr_pend_slot.sv
module mr_pend_slot #(
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [ADDR_W-1:0] in_op,
  output logic              full,
  output logic [SEL_W-1:0]  out_sel,
  output logic [ADDR_W-1:0] out_op
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      out_sel <= '0;
      out_op  <= '0;
    end else if (load) begin
      full    <= 1'b1;
      out_sel <= in_sel;
      out_op  <= in_op;
    end else if (take) begin
      full    <= 1'b0;
    end
  end
endmodule

// File: rtl/mr_delay_timer.sv
module mr_delay_timer #(
  parameter int UPD_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic expire
);
  localparam int CNT_W = (UPD_CYC > 2) ? $clog2(UPD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_CYC - 1);

  logic [CNT_W-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age     <= '0;
      running <= 1'b0;
    end else if (start) begin
      age     <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (age == LAST) running <= 1'b0;
      else             age     <= age + 1'b1;
    end
  end

  assign expire = running && (age == LAST);
endmodule

// File: rtl/mr_write_seq.sv
module mr_write_seq
  import mr_write_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int SEL_W     = 3,
  parameter int ADDR_W    = 14,
  parameter int UPD_CYC   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [SEL_W-1:0]     req_sel,
  input  logic [ADDR_W-1:0]    req_opcode,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic [NUM_BANKS-1:0] bank_trp_busy,
  input  logic                 burst_active,
  input  logic                 cke_high,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [SEL_W-1:0]     ba,
  output logic [ADDR_W-1:0]    addr,
  output logic                 busy,
  output logic                 done
);
  phase_t            phase_q, phase_d;
  cmd_t              cmd_q, cmd_d;
  logic [SEL_W-1:0]  ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  logic              dev_idle;
  logic              slot_full;
  logic [SEL_W-1:0]  slot_sel;
  logic [ADDR_W-1:0] slot_op;
  logic              win_running;
  logic              window_end;
  logic              accept_req;
  logic              issue_mrs;

  mr_idle_gate #(.NUM_BANKS(NUM_BANKS)) u_gate (
    .bank_open     (bank_open),
    .bank_trp_busy (bank_trp_busy),
    .burst_active  (burst_active),
    .cke_high      (cke_high),
    .dev_idle      (dev_idle)
  );

  assign busy       = refuse_req(slot_full, phase_q);
  assign accept_req = req_valid && !busy;
  assign issue_mrs  = slot_full && dev_idle &&
                      ((phase_q == PH_IDLE) || (phase_q == PH_WIN));

  mr_pend_slot #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_req),
    .take    (issue_mrs),
    .in_sel  (req_sel),
    .in_op   (req_opcode),
    .full    (slot_full),
    .out_sel (slot_sel),
    .out_op  (slot_op)
  );

  mr_delay_timer #(.UPD_CYC(UPD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (issue_mrs),
    .running (win_running),
    .expire  (window_end)
  );

  always_comb begin
    phase_d = phase_q;
    cmd_d   = cmd_des();
    ba_d    = '0;
    addr_d  = '0;
    if (issue_mrs) begin
      phase_d = PH_WIN;
      cmd_d   = cmd_mrs();
      ba_d    = slot_sel;
      addr_d  = slot_op;
    end else begin
      unique case (phase_q)
        PH_WIN: begin
          if (window_end || !win_running) phase_d = PH_DONE;
          else                            cmd_d   = cmd_nop();
        end
        PH_DONE: phase_d = PH_GAP;
        PH_GAP:  phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cmd_q   <= cmd_des();
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
    end
  end

  assign cs_n  = cmd_q.cs_n;
  assign ras_n = cmd_q.ras_n;
  assign cas_n = cmd_q.cas_n;
  assign we_n  = cmd_q.we_n;
  assign ba    = ba_q;
  assign addr  = addr_q;
  assign done  = (phase_q == PH_DONE);
endmodule

// File: rtl/mr_write_seq_chk.sv
module mr_write_seq_chk #(
  parameter int NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] bank_trp_busy,
  input logic                 burst_active,
  input logic                 cke_high,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic                 busy,
  input logic                 done
);
  logic bus_mrs, bus_nop;
  assign bus_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  assign bus_nop = !cs_n && ras_n && cas_n && we_n;

  a_r3_no_mrs_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mrs |-> ($past(bank_open) == '0));

  a_r4_no_mrs_trp_running: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mrs |-> ($past(bank_trp_busy) == '0));

  a_r5_no_mrs_burst_or_cke: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mrs |-> ($past(cke_high) && !$past(burst_active)));

  a_r6_nop_follows_mrs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mrs |=> (bus_nop || bus_mrs));

  a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !bus_mrs));

  a_r10_busy_around_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy ##1 busy);
endmodule

bind mr_write_seq mr_write_seq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bank_open     (bank_open),
  .bank_trp_busy (bank_trp_busy),
  .burst_active  (burst_active),
  .cke_high      (cke_high),
  .cs_n          (cs_n),
  .ras_n         (ras_n),
  .cas_n         (cas_n),
  .we_n          (we_n),
  .busy          (busy),
  .done          (done)
);

// File: tb/mr_write_seq_tb.sv
module mr_write_seq_tb;
  localparam int NB = 8;
  localparam int SW = 3;
  localparam int AW = 14;
  localparam int T  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_sel = '0;
  logic [AW-1:0] req_opcode = '0;
  logic [NB-1:0] bank_open = '0;
  logic [NB-1:0] bank_trp_busy = '0;
  logic          burst_active = 1'b0;
  logic          cke_high = 1'b1;
  logic          cs_n, ras_n, cas_n, we_n, busy, done;
  logic [SW-1:0] ba;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  mr_write_seq #(.NUM_BANKS(NB), .SEL_W(SW), .ADDR_W(AW), .UPD_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_opcode(req_opcode), .bank_open(bank_open), .bank_trp_busy(bank_trp_busy),
    .burst_active(burst_active), .cke_high(cke_high), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .busy(busy), .done(done)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Behavioural reference: a queue for the pending request, integers for the rest.
  int pend_q[$];                 // packed {sel, opcode}
  int in_window = 0;             // 1 while the update window runs
  int since_mrs = 0;             // cycles since the last MRS
  int post_done = 0;             // 2 on done cycle, 1 on the cycle after
  int exp_cmd = 0;               // 0 deselect, 1 nop, 2 mrs
  int exp_ba = 0, exp_addr = 0;
  int blk_tag = 11;              // requirement that explains a deselect
  bit reissue = 0;
  int mrs_seen = 0, mrs_model = 0;

  function automatic bit model_busy();
    return (pend_q.size() != 0) || (post_done != 0);
  endfunction

  task automatic model_step();
    bit ok, fire, take;
    int v;
    ok   = (bank_open == 0) && (bank_trp_busy == 0) && !burst_active && cke_high;
    take = req_valid && !model_busy();
    fire = (pend_q.size() != 0) && ok && (post_done == 0);
    if (bank_open != 0)                  blk_tag = 3;
    else if (bank_trp_busy != 0)         blk_tag = 4;
    else if (burst_active || !cke_high)  blk_tag = 5;
    else if (post_done != 0)             blk_tag = 10;
    else                                 blk_tag = 11;
    exp_ba = 0; exp_addr = 0; exp_cmd = 0;
    if (post_done > 0) post_done = post_done - 1;
    if (fire) begin
      v = pend_q.pop_front();
      reissue = (in_window != 0);
      exp_cmd = 2; exp_ba = v >>> AW; exp_addr = v % (1 << AW);
      in_window = 1; since_mrs = 0; mrs_model++;
    end else if (in_window != 0) begin
      since_mrs++;
      if (since_mrs >= T) begin in_window = 0; post_done = 2; end
      else exp_cmd = 1;
    end
    if (take) pend_q.push_back((int'(req_sel) << AW) | int'(req_opcode));
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int act_cmd;
    string ctag;
    act_cmd = (cs_n) ? 0 : (!ras_n && !cas_n && !we_n) ? 2 :
              (ras_n && cas_n && we_n) ? 1 : 3;
    if (act_cmd == 2) mrs_seen++;
    if (exp_cmd == 2)      ctag = reissue ? "R8 reissue in window" : "R2 MRS encoding";
    else if (exp_cmd == 1) ctag = "R6 NOP in window";
    else begin
      case (blk_tag)
        3: ctag = "R3 bank open blocks MRS";
        4: ctag = "R4 precharge interval blocks MRS";
        5: ctag = "R5 burst/cke blocks MRS";
        10: ctag = "R10 post-done quiet";
        default: ctag = "R11 deselect when idle";
      endcase
    end
    chk(act_cmd == exp_cmd, ctag, act_cmd, exp_cmd);
    chk(int'(ba) == exp_ba, {ctag, " ba"}, int'(ba), exp_ba);
    chk(int'(addr) == exp_addr, {ctag, " addr"}, int'(addr), exp_addr);
    chk(done == (post_done == 2), "R7 done pulse", int'(done), int'(post_done == 2));
    chk(busy == model_busy(), (post_done != 0) ? "R10 busy around done" : "R9 busy with slot",
        int'(busy), int'(model_busy()));
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic ask(input int sel, input int op);
    req_valid = 1'b1; req_sel = SW'(sel); req_opcode = AW'(op);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 4 * T; i++) begin
      if (!busy && (pend_q.size() == 0) && (in_window == 0) && (post_done == 0)) break;
      tick();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state during reset
    chk(cs_n && ras_n && cas_n && we_n && ba == 0 && addr == 0, "R1 reset bus", int'(cs_n), 1);
    chk(!busy && !done, "R1 reset flags", int'(busy) + int'(done), 0);
    rst_n = 1'b1;
    tick();
    chk(cs_n && !busy && !done, "R1 first cycle after reset", int'(cs_n), 1);

    // R2/R6/R7: plain request on an idle device
    ask(2, 14'h1A5);
    repeat (T + 4) tick();

    // R3: bank 3 open holds the request
    bank_open = 8'h08;
    ask(1, 14'h0F0);
    repeat (6) tick();
    bank_open = '0;
    repeat (T + 4) tick();

    // R4: precharge interval still running on bank 7
    bank_trp_busy = 8'h80;
    ask(0, 14'h3FFF);
    repeat (5) tick();
    bank_trp_busy = '0;
    repeat (T + 4) tick();

    // R5: burst in flight, then clock enable low
    burst_active = 1'b1;
    ask(3, 14'h0001);
    repeat (4) tick();
    burst_active = 1'b0; cke_high = 1'b0;
    repeat (4) tick();
    cke_high = 1'b1;
    repeat (T + 4) tick();

    // R8: second request inside the window restarts it
    ask(4, 14'h0222);
    repeat (5) tick();
    ask(5, 14'h0333);
    repeat (T + 4) tick();

    // R9: request while the slot is held is dropped
    bank_open = 8'h01;
    ask(6, 14'h0444);
    ask(7, 14'h0555);
    repeat (3) tick();
    bank_open = '0;
    repeat (T + 4) tick();

    // R10: requests on the done cycle and the cycle after are dropped
    ask(1, 14'h0666);
    while (!done) tick();
    req_valid = 1'b1; req_sel = 3'd2; req_opcode = 14'h0777;
    tick(); tick();
    req_valid = 1'b0;
    repeat (T + 4) tick();

    // Random mix over all conditions (R2-R11)
    for (int n = 0; n < 3000; n++) begin
      req_valid     = ($urandom_range(0, 9) < 3);
      req_sel       = SW'($urandom);
      req_opcode    = AW'($urandom);
      bank_open     = ($urandom_range(0, 9) < 2) ? NB'(1 << $urandom_range(0, NB - 1)) : '0;
      bank_trp_busy = ($urandom_range(0, 9) < 2) ? NB'(1 << $urandom_range(0, NB - 1)) : '0;
      burst_active  = ($urandom_range(0, 9) < 1);
      cke_high      = ($urandom_range(0, 19) != 0);
      tick();
    end
    req_valid = 1'b0; bank_open = '0; bank_trp_busy = '0; burst_active = 1'b0; cke_high = 1'b1;
    wait_quiet();
    repeat (T + 4) tick();
    // R8: total commands issued agree with the model
    chk(mrs_seen == mrs_model, "R8 MRS count", mrs_seen, mrs_model);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished t=%0t", $time);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule